// File: doc/BRIEF.md
# Stop-clock wake-up controller

This block puts the CPU into a low-power standby by gating its clock, and brings it back when one of four selected events occurs. A single register write does both jobs. The written bits say which event sources may end the standby, and a non-zero write stops the CPU clock. While the CPU clock is off, an always-on low-frequency clock keeps watching the event inputs. Those inputs are a port pin-change group, a timer 0 overflow, a fast time-base tick and a slow time-base tick.

When an enabled source shows a new rising edge, the clock is released. The CPU then gets a short reset of its own, so it restarts from its reset vector rather than resuming. RAM and I/O are not on this reset and keep their contents. A cause register records which enabled sources ended the standby. Software reads it after the restart, and a read clears it.

Top module: `stopclk_wake_ctrl`

## Requirements
- R1: A write with a non-zero value on `wr_data_i` raises `standby_o` and stops `clk_cpu_o`, with no rising edges, within a few main-clock cycles.
- R2: A write of all zeros neither enters standby nor stops `clk_cpu_o`.
- R3: In standby, a rising edge on an enabled event input ends standby. `cpu_rst_no` goes low and `clk_cpu_o` runs again.
- R4: In standby, edges on event inputs whose enable bit is 0 do not end standby.
- R5: After a wake-up, `cpu_rst_no` stays low for exactly 4 main-clock cycles, and `clk_cpu_o` gives one rising edge in each of them.
- R6: The cause value on `rd_cause_o` holds the enabled sources that ended standby. Bit 0 is the port group, bit 1 is timer 0, bit 2 is the fast tick and bit 3 is the slow tick. The same bit order applies to `wr_data_i` and `ev_i`.
- R7: A cycle with `rd_en_i` high clears the cause value. If a wake-up is captured in that same cycle, the new cause is kept.
- R8: Event edges that arrive while not in standby do not end a standby entered later.
- R9: Writes made while in standby leave the source enables unchanged.
- R10: After `rst_ni` is released, `standby_o` is 0, `cpu_rst_no` is 1, the cause is 0 and `clk_cpu_o` runs.
- R11: An event input already high before standby is entered does not wake the block. Only a fresh rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main_i | input | 1 | Free-running main clock; the source of the CPU clock |
| clk_lf_i | input | 1 | Always-on low-frequency clock that samples the events |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the stop-clock register |
| wr_data_i | input | 4 | Source enables; a non-zero value enters standby |
| rd_en_i | input | 1 | Read strobe for the cause register; clears it |
| rd_cause_o | output | 4 | Current wake-cause value |
| ev_i | input | 4 | Wake event inputs (port, timer 0, fast tick, slow tick) |
| clk_cpu_o | output | 1 | Gated CPU clock |
| cpu_rst_no | output | 1 | Active-low CPU-only reset |
| standby_o | output | 1 | High while the CPU clock is stopped |

## Verification
Two actions can meet in the same main-clock cycle: a read that clears the cause value, and a wake-up capture that sets it. The bench holds the read strobe high through an entire standby. It fires an enabled event and drops the strobe in the same cycle that the CPU reset first shows low. The result is judged correct only if the cause still shows the waking source afterwards, which means the capture won over the clear.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
  localparam int unsigned NSRC = 4;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WRST = 2'd2
  } seq_st_e;
endpackage

// File: rtl/stopclk_rst_sync.sv
module stopclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] shf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shf_q <= '0;
    else         shf_q <= {shf_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = shf_q[STAGES-1];
endmodule

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/stopclk_evt_capture.sv
module stopclk_evt_capture #(
  parameter int unsigned NSRC     = 4,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic            clk_lf_i,
  input  logic            rst_lf_ni,
  input  logic            arm_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] ev_i,
  output logic [NSRC-1:0] pend_o
);
  logic            arm_s;
  logic [NSRC-1:0] ev_s;
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_n;
  logic [NSRC-1:0] rise;

  stopclk_sync #(.W(1), .STAGES(SYNC_STG)) u_arm_sync (
    .clk_i(clk_lf_i), .rst_ni(rst_lf_ni), .d_i(arm_i), .q_o(arm_s)
  );

  stopclk_sync #(.W(NSRC), .STAGES(SYNC_STG)) u_ev_sync (
    .clk_i(clk_lf_i), .rst_ni(rst_lf_ni), .d_i(ev_i), .q_o(ev_s)
  );

  // Only fresh 0->1 transitions count as events
  assign rise = ev_s & ~prev_q;

  always_comb begin
    if (arm_s) pend_n = pend_q | (rise & en_i);
    else       pend_n = '0;
  end

  always_ff @(posedge clk_lf_i or negedge rst_lf_ni) begin
    if (!rst_lf_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= ev_s;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;

  // R3: a captured event stays captured while armed
  p_pend_hold_r3: assert property (@(posedge clk_lf_i) disable iff (!rst_lf_ni)
    arm_s |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R8: nothing is captured while disarmed
  p_idle_empty_r8: assert property (@(posedge clk_lf_i) disable iff (!rst_lf_ni)
    (!arm_s && !$past(arm_s)) |-> (pend_q == '0));
endmodule

// File: rtl/stopclk_cg.sv
module stopclk_cg (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_lat;

  // Enable may only change while the clock is low
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/stopclk_seq.sv
module stopclk_seq
  import stopclk_pkg::*;
#(
  parameter int unsigned NSRC    = 4,
  parameter int unsigned RST_CYC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic            rd_en_i,
  input  logic [NSRC-1:0] pend_i,
  output logic [NSRC-1:0] en_o,
  output logic            arm_o,
  output logic            gate_en_o,
  output logic            cpu_rst_no,
  output logic            standby_o,
  output logic [NSRC-1:0] cause_o
);
  localparam int unsigned CNT_W = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYC - 1);

  seq_st_e         state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [NSRC-1:0] en_q, en_n;
  logic            req_q, req_n;
  logic [NSRC-1:0] cause_q, cause_n;
  logic            gate_q, gate_n;
  logic            crst_q, crst_n;
  logic [NSRC-1:0] hit;

  assign hit = pend_i & en_q;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    en_n    = en_q;
    req_n   = req_q;
    cause_n = cause_q;
    if (rd_en_i) cause_n = '0;
    unique case (state_q)
      ST_RUN: begin
        if (req_q && (pend_i == '0)) begin
          state_n = ST_STOP;
          req_n   = 1'b0;
        end else if (wr_en_i && (wr_data_i != '0)) begin
          en_n  = wr_data_i;
          req_n = 1'b1;
        end
      end
      ST_STOP: begin
        if (hit != '0) begin
          state_n = ST_WRST;
          cnt_n   = '0;
          cause_n = hit;
        end
      end
      ST_WRST: begin
        if (cnt_q == CNT_LAST) state_n = ST_RUN;
        else                   cnt_n   = cnt_q + CNT_W'(1);
      end
      default: state_n = ST_RUN;
    endcase
    gate_n = (state_n != ST_STOP);
    crst_n = (state_n != ST_WRST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      en_q    <= '0;
      req_q   <= 1'b0;
      cause_q <= '0;
      gate_q  <= 1'b1;
      crst_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      en_q    <= en_n;
      req_q   <= req_n;
      cause_q <= cause_n;
      gate_q  <= gate_n;
      crst_q  <= crst_n;
    end
  end

  assign en_o       = en_q;
  assign arm_o      = (state_q == ST_STOP);
  assign gate_en_o  = gate_q;
  assign cpu_rst_no = crst_q;
  assign standby_o  = (state_q == ST_STOP);
  assign cause_o    = cause_q;

  // R1: clock enable is off throughout standby
  p_gate_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> !gate_q);

  // R2: an all-zero write raises no stop request
  p_zero_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !req_q && wr_en_i && wr_data_i == '0) |=> !req_q);

  // R5: the CPU clock runs while its reset is held
  p_rst_clk_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crst_q |-> gate_q);

  // R6: an enabled hit in standby leads to reset and a non-zero cause
  p_cause_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && hit != '0) |=> (!crst_q && cause_q != '0));

  // R7: a read outside standby leaves the cause empty
  p_rd_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && state_q != ST_STOP) |=> (cause_q == '0));

  // R9: enables change only while running
  p_en_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |=> $stable(en_q));
endmodule

// File: rtl/stopclk_wake_ctrl.sv
module stopclk_wake_ctrl #(
  parameter int unsigned NSRC     = stopclk_pkg::NSRC,
  parameter int unsigned RST_CYC  = 4,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic            clk_main_i,
  input  logic            clk_lf_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic            rd_en_i,
  output logic [NSRC-1:0] rd_cause_o,
  input  logic [NSRC-1:0] ev_i,
  output logic            clk_cpu_o,
  output logic            cpu_rst_no,
  output logic            standby_o
);
  logic            rst_main_n;
  logic            rst_lf_n;
  logic            arm;
  logic            gate_en;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] pend_lf;
  logic [NSRC-1:0] pend_main;

  stopclk_rst_sync #(.STAGES(SYNC_STG)) u_rst_main (
    .clk_i(clk_main_i), .rst_ni(rst_ni), .rst_no(rst_main_n)
  );

  stopclk_rst_sync #(.STAGES(SYNC_STG)) u_rst_lf (
    .clk_i(clk_lf_i), .rst_ni(rst_ni), .rst_no(rst_lf_n)
  );

  stopclk_evt_capture #(.NSRC(NSRC), .SYNC_STG(SYNC_STG)) u_capture (
    .clk_lf_i (clk_lf_i),
    .rst_lf_ni(rst_lf_n),
    .arm_i    (arm),
    .en_i     (en),
    .ev_i     (ev_i),
    .pend_o   (pend_lf)
  );

  stopclk_sync #(.W(NSRC), .STAGES(SYNC_STG)) u_pend_sync (
    .clk_i(clk_main_i), .rst_ni(rst_main_n), .d_i(pend_lf), .q_o(pend_main)
  );

  stopclk_seq #(.NSRC(NSRC), .RST_CYC(RST_CYC)) u_seq (
    .clk_i     (clk_main_i),
    .rst_ni    (rst_main_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .pend_i    (pend_main),
    .en_o      (en),
    .arm_o     (arm),
    .gate_en_o (gate_en),
    .cpu_rst_no(cpu_rst_no),
    .standby_o (standby_o),
    .cause_o   (rd_cause_o)
  );

  stopclk_cg u_cg (
    .clk_i(clk_main_i), .en_i(gate_en), .clk_o(clk_cpu_o)
  );
endmodule

// File: tb/stopclk_wake_ctrl_bench.sv
module stopclk_wake_ctrl_bench;
  logic       clk_main = 1'b0;
  logic       clk_lf   = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_data;
  logic       rd_en;
  logic [3:0] rd_cause;
  logic [3:0] ev;
  logic       clk_cpu;
  logic       cpu_rst_n;
  logic       standby;

  int n_chk  = 0;
  int n_fail = 0;
  int cpu_edges = 0;
  bit done = 1'b0;

  always #4  clk_main = ~clk_main;
  always #20 clk_lf   = ~clk_lf;
  always @(posedge clk_cpu) cpu_edges++;

  stopclk_wake_ctrl u_stopclk_wake_ctrl (
    .clk_main_i(clk_main), .clk_lf_i(clk_lf), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_cause_o(rd_cause), .ev_i(ev), .clk_cpu_o(clk_cpu),
    .cpu_rst_no(cpu_rst_n), .standby_o(standby)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_main);
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk_main); wr_en = 1'b1; wr_data = d;
    @(negedge clk_main); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_ev(input int i);
    ev[i] = 1'b1; repeat (3) @(negedge clk_lf);
    ev[i] = 1'b0; repeat (3) @(negedge clk_lf);
  endtask

  task automatic enter_stop(input logic [3:0] d, input string tag);
    int e0;
    wr(d);
    for (int k = 0; k < 60 && !standby; k++) cyc(1);
    chk(standby == 1'b1, {tag, " R1 standby"}, standby, 1);
    e0 = cpu_edges;
    cyc(20);
    chk(cpu_edges == e0, {tag, " R1 clock stopped"}, cpu_edges - e0, 0);
  endtask

  // waits for the CPU reset and measures its length and clock edges
  task automatic wait_wake(output bit woke, output int len, output int edges);
    int e0;
    woke = 1'b0; len = 0; edges = 0;
    for (int k = 0; k < 300 && cpu_rst_n; k++) cyc(1);
    if (!cpu_rst_n) begin
      woke = 1'b1;
      e0 = cpu_edges;
      while (!cpu_rst_n && len < 50) begin len++; cyc(1); end
      edges = cpu_edges - e0;
    end
  endtask

  task automatic read_clear(input string tag);
    @(negedge clk_main); rd_en = 1'b1;
    @(negedge clk_main); rd_en = 1'b0;
    chk(rd_cause == 4'b0, {tag, " R7 read clears"}, rd_cause, 0);
  endtask

  task automatic wake_by(input int s, input logic [3:0] exp_cause, input string tag);
    bit woke; int len; int edges;
    ev[s] = 1'b1;
    wait_wake(woke, len, edges);
    chk(woke, {tag, " R3 wake"}, woke, 1);
    chk(len == 4, {tag, " R5 reset length"}, len, 4);
    chk(edges == 4, {tag, " R5 clock edges in reset"}, edges, 4);
    ev[s] = 1'b0;
    repeat (3) @(negedge clk_lf);
    chk(rd_cause == exp_cause, {tag, " R6 cause"}, rd_cause, exp_cause);
  endtask

  task automatic t_reset;
    int e0;
    chk(standby == 1'b0, "R10 standby", standby, 0);
    chk(cpu_rst_n == 1'b1, "R10 cpu reset", cpu_rst_n, 1);
    chk(rd_cause == 4'b0, "R10 cause", rd_cause, 0);
    e0 = cpu_edges; cyc(10);
    chk(cpu_edges - e0 == 10, "R10 clock runs", cpu_edges - e0, 10);
  endtask

  task automatic t_zero_write;
    int e0;
    wr(4'b0000); cyc(10);
    chk(standby == 1'b0, "R2 no standby", standby, 0);
    e0 = cpu_edges; cyc(10);
    chk(cpu_edges - e0 == 10, "R2 clock runs", cpu_edges - e0, 10);
  endtask

  task automatic t_each_source;
    for (int s = 0; s < 4; s++) begin
      enter_stop(4'(1 << s), "single");
      wake_by(s, 4'(1 << s), "single");
      read_clear("single");
    end
  endtask

  task automatic t_disabled;
    enter_stop(4'b0001, "disabled");
    pulse_ev(2); pulse_ev(3); pulse_ev(1);
    cyc(100);
    chk(standby == 1'b1, "R4 disabled edges ignored", standby, 1);
    wake_by(0, 4'b0001, "disabled");
    read_clear("disabled");
  endtask

  task automatic t_multi_enable;
    enter_stop(4'b1111, "multi");
    wake_by(2, 4'b0100, "multi R6");
    read_clear("multi");
  endtask

  task automatic t_outside;
    pulse_ev(1); cyc(10);
    enter_stop(4'b0010, "outside");
    cyc(200);
    chk(standby == 1'b1, "R8 earlier edge ignored", standby, 1);
    wake_by(1, 4'b0010, "outside");
    read_clear("outside");
  endtask

  task automatic t_held;
    ev[3] = 1'b1; repeat (3) @(negedge clk_lf);
    enter_stop(4'b1000, "held");
    cyc(200);
    chk(standby == 1'b1, "R11 held level ignored", standby, 1);
    ev[3] = 1'b0; repeat (4) @(negedge clk_lf);
    wake_by(3, 4'b1000, "held R11");
    read_clear("held");
  endtask

  task automatic t_write_in_stop;
    enter_stop(4'b0001, "wrstop");
    wr(4'b0100);
    pulse_ev(2); cyc(100);
    chk(standby == 1'b1, "R9 write in standby ignored", standby, 1);
    wake_by(0, 4'b0001, "wrstop R9");
    read_clear("wrstop");
  endtask

  task automatic t_collide;
    bit seen;
    enter_stop(4'b0010, "collide");
    @(negedge clk_main); rd_en = 1'b1;
    ev[1] = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 300 && !seen; k++) begin
      @(negedge clk_main);
      if (!cpu_rst_n) begin rd_en = 1'b0; seen = 1'b1; end
    end
    rd_en = 1'b0;
    chk(seen, "R7 collide wake", seen, 1);
    ev[1] = 1'b0; repeat (3) @(negedge clk_lf);
    chk(rd_cause == 4'b0010, "R7 capture beats clear", rd_cause, 2);
    read_clear("collide");
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; ev = '0;
    repeat (5) @(negedge clk_main);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_lf);
    t_reset;
    t_zero_write;
    t_each_source;
    t_disabled;
    t_multi_enable;
    t_outside;
    t_held;
    t_write_in_stop;
    t_collide;
    done = 1'b1;
    summary;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary;
    end
  end
endmodule